// File: doc/BRIEF.md
# Command-driven SPI master

This block is an SPI bus master that serializes frames taken from a small transmit queue. Each queued entry pairs a data word with a command. A 3-bit selector in the command picks one of eight stored attribute sets: clock polarity, clock phase, frame length and SCK divider. The chosen set governs that frame alone, so neighbouring frames may use entirely different timing and modes. Every word shifted in on MISO is placed in a small receive queue.

A run/stop state machine controls when frames may begin. It leaves STOPPED only when master mode is on, no halt or freeze is requested, the module is enabled, and work is queued. It returns to STOPPED only between frames, so a frame that has started always completes. The attribute sets can be changed only while the block is stopped. A debug request stops the block only when freeze is enabled. A module-disable input suspends the serial engine and the state machine wherever they are, and the register contents are kept.

Top module: `spc_master`

## Requirements
- R1: After a synchronous reset the block is STOPPED (`running`=0), with `cs_n`=1, `sck`=0, `rx_empty`=1 and `rx_ovf`=0, and every attribute set is zero.
- R2: The block moves to RUNNING (`running`=1) only when master_en=1, halt=0, no freeze request is present, `mdis`=0 and the transmit queue is not empty. While `running`=0, no frame starts (`cs_n` does not fall).
- R3: Bits [2:0] of `tx_cmd` choose which of the eight attribute sets the frame uses. The choice applies to that frame only.
- R4: Attribute word layout: bit 0 CPOL, bit 1 CPHA, bits [5:2] frame length minus one, bits [15:6] divider D. Length values below 3 count as 3, giving frames of 4 to 16 bits. Each SCK half-period lasts D+1 clock cycles. When `cs_n` falls, `sck` is at CPOL.
- R5: A frame of N bits shifts data MSB first and produces exactly 2N SCK edges. With CPHA=0, data is sampled on leading edges and changed on trailing edges. With CPHA=1, data is changed on leading edges and sampled on trailing edges.
- R6: The first SCK edge comes D+1 cycles after `cs_n` falls. `cs_n` rises D+1 cycles after the last edge.
- R7: When `cs_n` rises, the received N-bit word, zero-extended to 16 bits, is pushed into a 4-entry receive queue. Words are read in order from `rx_data` using `rx_pop`.
- R8: If a frame completes while the receive queue is full, `rx_ovf` is set and stays set, the new word is dropped, and the queued words are kept.
- R9: Setting halt, or clearing master_en, stops the block at the next frame boundary. The frame in progress completes, and no further frame starts.
- R10: With freeze_en=1, a high `dbg_req` acts as a stop request at the next frame boundary. With freeze_en=0, `dbg_req` has no effect.
- R11: While `mdis`=1, the serial engine and the run state hold, so `sck`, `mosi`, `cs_n` and `running` stay unchanged. A suspended frame resumes and completes correctly after `mdis` falls.
- R12: Configuration addresses 0 to 7 hold the attribute sets. Address 8 is the control register: bit 0 master_en, bit 1 halt, bit 2 freeze_en. Control writes are always accepted. Attribute writes are ignored while `running`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration address (0-7 attribute sets, 8 control) |
| cfg_wdata | input | 16 | Configuration write data |
| dbg_req | input | 1 | Debug request |
| mdis | input | 1 | Module disable |
| tx_push | input | 1 | Push one entry into the transmit queue |
| tx_cmd | input | 3 | Command: attribute set selector |
| tx_data | input | 16 | Frame data, right-aligned |
| tx_full | output | 1 | Transmit queue full |
| rx_pop | input | 1 | Pop the head of the receive queue |
| rx_data | output | 16 | Head of the receive queue |
| rx_empty | output | 1 | Receive queue empty |
| rx_ovf | output | 1 | Sticky receive overflow flag |
| running | output | 1 | 1 in RUNNING, 0 in STOPPED |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
A wrong attribute set, a miscounted edge or a wrong phase shows up on the serial pins within the same frame. It appears as a wrong idle level when `cs_n` falls, a half-period of the wrong length, or a mismatched word at the slave model when `cs_n` rises. A corrupted run state or a stop taken mid-frame shows as a chip select that falls when it should not, or as a frame cut short. Both are visible within a few divider periods. A receive-queue fault is seen only when the word is popped, which can be several frames later. The overflow flag and the contents of the queue are therefore checked directly after a fifth frame is forced in.

// File: rtl/spc_pkg.sv
package spc_pkg;
  localparam int DATA_W = 16;
  localparam int DIV_W  = 10;
  localparam int LEN_W  = $clog2(DATA_W);
  localparam int EDGE_W = LEN_W + 2;

  // one attribute set, laid out exactly as the configuration word
  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [LEN_W-1:0] len_m1;
    logic             cpha;
    logic             cpol;
  } attr_t;

  typedef enum logic [1:0] {E_IDLE, E_SHIFT, E_TRAIL} eng_state_t;
endpackage

// File: rtl/spc_fifo.sv
module spc_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         empty
);
  logic [W-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;
  logic do_wr, do_rd;

  assign full    = (cnt == (PW+1)'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= wp + 1'b1;
      if (do_rd) rp <= rp + 1'b1;
      if (do_wr && !do_rd) cnt <= cnt + 1'b1;
      else if (do_rd && !do_wr) cnt <= cnt - 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_en) |=> (full && $stable(wp))) else $error("write into full queue"); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty && !wr_en) |=> (empty && $stable(rp))) else $error("read from empty queue"); // R7
endmodule

// File: rtl/spc_attr_bank.sv
module spc_attr_bank
  import spc_pkg::*;
#(
  parameter int NUM_SETS = 8,
  parameter int AW       = 4,
  parameter int SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  attr_t            wdata,
  input  logic             lock,
  input  logic [SEL_W-1:0] sel,
  output attr_t            rd
);
  attr_t bank [NUM_SETS];
  logic  wr_hit;

  assign wr_hit = we && !lock && (addr < AW'(NUM_SETS));
  assign rd     = bank[sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SETS; i++) bank[i] <= '0;
    end else if (wr_hit) begin
      bank[addr[SEL_W-1:0]] <= wdata;
    end
  end

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_lock_chk
    AST_ATTR_LOCK: assert property (@(posedge clk) disable iff (rst)
      (we && lock) |=> $stable(bank[g])) else $error("attribute changed while running"); // R12
  end
endmodule

// File: rtl/spc_shifter.sv
module spc_shifter
  import spc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              start,
  input  attr_t             attr,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              cs_n,
  output logic              idle,
  output logic              done,
  output logic [DATA_W-1:0] rx_word
);
  eng_state_t        state;
  logic [DIV_W-1:0]  cnt, div_q;
  logic [EDGE_W-1:0] edges;
  logic              cpha_q;
  logic [DATA_W-1:0] txs, rxs;

  logic [LEN_W-1:0]  lm;
  logic [LEN_W:0]    flen;
  logic [DATA_W-1:0] tinit;

  always_comb begin
    lm    = (attr.len_m1 < LEN_W'(3)) ? LEN_W'(3) : attr.len_m1;
    flen  = {1'b0, lm} + 1'b1;
    tinit = tx_word << ((LEN_W+1)'(DATA_W) - flen);
  end

  assign idle = (state == E_IDLE);

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      state   <= E_IDLE;
      sck     <= 1'b0;
      mosi    <= 1'b0;
      cs_n    <= 1'b1;
      cnt     <= '0;
      div_q   <= '0;
      edges   <= '0;
      cpha_q  <= 1'b0;
      txs     <= '0;
      rxs     <= '0;
      rx_word <= '0;
    end else if (en) begin
      case (state)
        E_IDLE: if (start) begin
          cs_n   <= 1'b0;
          sck    <= attr.cpol;
          cpha_q <= attr.cpha;
          div_q  <= attr.div;
          cnt    <= attr.div;
          edges  <= {flen, 1'b0} - EDGE_W'(1);
          rxs    <= '0;
          if (attr.cpha) begin
            mosi <= 1'b0;
            txs  <= tinit;
          end else begin
            mosi <= tinit[DATA_W-1];
            txs  <= {tinit[DATA_W-2:0], 1'b0};
          end
          state <= E_SHIFT;
        end
        E_SHIFT: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            cnt <= div_q;
            sck <= ~sck;
            // odd remaining count marks a leading edge
            if (edges[0] ^ cpha_q) begin
              rxs <= {rxs[DATA_W-2:0], miso};
            end else begin
              mosi <= txs[DATA_W-1];
              txs  <= {txs[DATA_W-2:0], 1'b0};
            end
            if (edges == '0) state <= E_TRAIL;
            else edges <= edges - 1'b1;
          end
        end
        E_TRAIL: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            cs_n    <= 1'b1;
            done    <= 1'b1;
            rx_word <= rxs;
            state   <= E_IDLE;
          end
        end
        default: state <= E_IDLE;
      endcase
    end
  end

  AST_SCK_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    !$stable(sck) |-> !cs_n) else $error("sck moved outside a frame"); // R5
  AST_MDIS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(sck) && $stable(cs_n) && $stable(mosi))) else $error("pins moved while disabled"); // R11
  AST_DONE_AT_CS_RISE: assert property (@(posedge clk) disable iff (rst)
    done |-> $rose(cs_n)) else $error("word delivered away from frame end"); // R7
endmodule

// File: rtl/spc_master.sv
module spc_master
  import spc_pkg::*;
#(
  parameter int NUM_SETS = 8,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  localparam int SEL_W   = $clog2(NUM_SETS),
  localparam int CFG_AW  = SEL_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              dbg_req,
  input  logic              mdis,
  input  logic              tx_push,
  input  logic [SEL_W-1:0]  tx_cmd,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_full,
  input  logic              rx_pop,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_empty,
  output logic              rx_ovf,
  output logic              running,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);
  localparam int TXW = SEL_W + DATA_W;

  logic master_en, halt, freeze_en, run_q;
  logic stop_req, start, eng_en, eng_idle, eng_done, tx_empty, rx_full;
  logic [TXW-1:0]    tx_head;
  logic [DATA_W-1:0] rx_word;
  attr_t             cur_attr;

  assign eng_en   = !mdis;
  assign stop_req = halt || !master_en || (freeze_en && dbg_req);
  assign start    = eng_en && run_q && eng_idle && !stop_req && !tx_empty;
  assign running  = run_q;

  // control register, writable in any state
  always_ff @(posedge clk) begin
    if (rst) begin
      master_en <= 1'b0;
      halt      <= 1'b0;
      freeze_en <= 1'b0;
    end else if (cfg_we && cfg_addr == CFG_AW'(NUM_SETS)) begin
      master_en <= cfg_wdata[0];
      halt      <= cfg_wdata[1];
      freeze_en <= cfg_wdata[2];
    end
  end

  // run/stop machine: both directions only between frames
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
    end else if (eng_en) begin
      if (!run_q && !stop_req && !tx_empty) run_q <= 1'b1;
      else if (run_q && eng_idle && stop_req) run_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rx_ovf <= 1'b0;
    else if (eng_done && rx_full) rx_ovf <= 1'b1;
  end

  spc_attr_bank #(.NUM_SETS(NUM_SETS), .AW(CFG_AW), .SEL_W(SEL_W)) attr_i (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(attr_t'(cfg_wdata)),
    .lock(run_q), .sel(tx_head[DATA_W +: SEL_W]), .rd(cur_attr));

  spc_fifo #(.W(TXW), .DEPTH(TX_DEPTH)) txq_i (
    .clk(clk), .rst(rst), .wr_en(tx_push), .wr_data({tx_cmd, tx_data}),
    .rd_en(start), .rd_data(tx_head), .full(tx_full), .empty(tx_empty));

  spc_fifo #(.W(DATA_W), .DEPTH(RX_DEPTH)) rxq_i (
    .clk(clk), .rst(rst), .wr_en(eng_done), .wr_data(rx_word),
    .rd_en(rx_pop), .rd_data(rx_data), .full(rx_full), .empty(rx_empty));

  spc_shifter eng_i (
    .clk(clk), .rst(rst), .en(eng_en), .start(start), .attr(cur_attr),
    .tx_word(tx_head[DATA_W-1:0]), .miso(miso), .sck(sck), .mosi(mosi),
    .cs_n(cs_n), .idle(eng_idle), .done(eng_done), .rx_word(rx_word));

  AST_CS_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> $past(run_q)) else $error("frame began while stopped"); // R2
  AST_STOP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    $fell(run_q) |-> $past(eng_idle)) else $error("stopped inside a frame"); // R9
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_ovf) |-> $past(eng_done && rx_full)) else $error("overflow flag without cause"); // R8
  AST_FREEZE_OFF: assert property (@(posedge clk) disable iff (rst)
    (!freeze_en && !halt && master_en && !mdis && run_q) |=> run_q) else $error("stopped without request"); // R10
endmodule

// File: tb/spc_master_tb.sv
module spc_master_tb_top;
  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 0, dbg_req = 0, mdis = 0, tx_push = 0, rx_pop = 0, miso = 0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0, tx_data = '0;
  logic [2:0]  tx_cmd = '0;
  logic tx_full, rx_empty, rx_ovf, running, sck, mosi, cs_n;
  logic [15:0] rx_data;

  always #2 clk = ~clk;

  spc_master dut_i (.clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .dbg_req(dbg_req), .mdis(mdis), .tx_push(tx_push),
    .tx_cmd(tx_cmd), .tx_data(tx_data), .tx_full(tx_full), .rx_pop(rx_pop),
    .rx_data(rx_data), .rx_empty(rx_empty), .rx_ovf(rx_ovf), .running(running),
    .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n));

  typedef struct { bit cpol; bit cpha; int len; int div; logic [15:0] tx; logic [15:0] reply; } item_t;
  item_t exp_q[$];
  logic [15:0] rx_model[$];
  logic [15:0] attr_model [8];
  int n_chk = 0, n_fail = 0, frames_done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] a, input logic [31:0] e);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0h exp=%0h", tag, a, e);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr_cfg(input logic [3:0] a, input logic [15:0] d, input bit model);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d; tick();
    cfg_we = 0;
    if (model && a < 4'd8) attr_model[a[2:0]] = d;
  endtask

  // driver: queues the frame and the scoreboard expectation
  task automatic push(input logic [2:0] sel, input logic [15:0] d, input logic [15:0] rep);
    item_t it;
    logic [15:0] w;
    int lm;
    w = attr_model[sel];
    lm = (w[5:2] < 3) ? 3 : int'(w[5:2]);
    it.cpol = w[0]; it.cpha = w[1]; it.len = lm + 1; it.div = int'(w[15:6]);
    it.tx = d; it.reply = rep;
    exp_q.push_back(it);
    tx_push = 1; tx_cmd = sel; tx_data = d; tick();
    tx_push = 0;
  endtask

  task automatic wait_frames(input int n);
    while (frames_done < n) tick();
  endtask

  task automatic drain(input string tag);
    while (rx_model.size() != 0) begin
      logic [15:0] e;
      e = rx_model.pop_front();
      chk(!rx_empty && rx_data === e, tag, rx_data, e);
      rx_pop = 1; tick(); rx_pop = 0;
    end
    chk(rx_empty === 1'b1, tag, rx_empty, 1);
  endtask

  // monitor: SPI slave model and pin-level scoreboard
  initial begin
    item_t cur;
    bit prev_cs, prev_sck, in_frame, mdis_prev, gap_bad;
    int act, last, edges;
    logic [15:0] acc, msh, mask;
    prev_cs = 1; prev_sck = 0; in_frame = 0; mdis_prev = 0; gap_bad = 0;
    act = 0; last = 0; edges = 0; acc = '0; msh = '0; mask = '0;
    forever begin
      @(negedge clk);
      if (rst) begin
        prev_cs = 1; prev_sck = sck; in_frame = 0; mdis_prev = 0;
      end else begin
        if (!mdis_prev) act++;
        if (prev_cs && !cs_n) begin
          chk(exp_q.size() != 0, "R3 frame expected", exp_q.size(), 1);
          if (exp_q.size() != 0) cur = exp_q.pop_front();
          chk(sck === cur.cpol, "R4 sck level at select", sck, cur.cpol);
          in_frame = 1; edges = 0; acc = '0; gap_bad = 0; last = act;
          mask = 16'((32'd1 << cur.len) - 1);
          msh = cur.reply << (16 - cur.len);
          if (!cur.cpha) begin miso = msh[15]; msh = msh << 1; end
        end else if (in_frame && !prev_cs && cs_n) begin
          chk(edges == 2 * cur.len, "R3 R5 edge count", edges, 2 * cur.len);
          chk((acc & mask) === (cur.tx & mask), "R5 mosi word", acc & mask, cur.tx & mask);
          chk(act - last == cur.div + 1, "R6 select hold after last edge", act - last, cur.div + 1);
          chk(!gap_bad, "R4 half-period length", gap_bad, 0);
          if (rx_model.size() < 4) rx_model.push_back(cur.reply & mask);
          in_frame = 0;
          frames_done++;
        end else if (in_frame && sck !== prev_sck) begin
          edges++;
          if (edges == 1) chk(act - last == cur.div + 1, "R6 select lead before first edge", act - last, cur.div + 1);
          else if (act - last != cur.div + 1) gap_bad = 1;
          last = act;
          if (((edges % 2) == 1) ^ cur.cpha) acc = {acc[14:0], mosi};
          else begin miso = msh[15]; msh = msh << 1; end
        end
        mdis_prev = mdis; prev_cs = cs_n; prev_sck = sck;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R2: watchdog expired act=0 exp=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic sck_h, cs_h, mosi_h;
    bit stable_ok;
    int fd;
    for (int i = 0; i < 8; i++) attr_model[i] = '0;
    tick(4); rst = 0; tick();
    // R1 reset state
    chk(running === 0 && cs_n === 1 && sck === 0, "R1 reset pins", {running, cs_n, sck}, 3'b010);
    chk(rx_empty === 1 && rx_ovf === 0, "R1 reset queue", {rx_empty, rx_ovf}, 2'b10);

    wr_cfg(4'd0, 16'h001C, 1);   // mode 0, 8 bits, D=0
    wr_cfg(4'd3, 16'h007F, 1);   // mode 3, 16 bits, D=1
    wr_cfg(4'd5, 16'h008E, 1);   // mode 1, 4 bits, D=2
    wr_cfg(4'd6, 16'h002D, 1);   // mode 2, 12 bits, D=0
    wr_cfg(4'd1, 16'h00FC, 1);   // mode 0, 16 bits, D=3
    wr_cfg(4'd2, 16'h0004, 1);   // length field 1 -> 4 bits

    // R3: per-frame selection across several modes
    push(3'd0, 16'h00A5, 16'h003C);
    push(3'd3, 16'hBEEF, 16'h1234);
    push(3'd5, 16'h0009, 16'h0006);
    push(3'd6, 16'h05A3, 16'h0C71);
    tick(10);
    chk(running === 0 && cs_n === 1, "R2 idle without master_en", {running, cs_n}, 2'b01);
    wr_cfg(4'd8, 16'h0001, 0);
    tick(2);
    chk(running === 1, "R2 running after enable", running, 1);
    wait_frames(4);
    tick(3);
    chk(running === 1, "R2 stays running on empty queue", running, 1);

    // R12: attribute write ignored while running; R8 overflow on fifth word
    wr_cfg(4'd0, 16'h0003, 0);
    push(3'd0, 16'h0081, 16'h00FF);
    wait_frames(5);
    tick(2);
    chk(rx_ovf === 1, "R8 overflow flag", rx_ovf, 1);
    drain("R7 R8 receive order");
    push(3'd2, 16'h000D, 16'h000A);   // R4 clamped length
    wait_frames(6);
    tick(2);
    drain("R4 R7 short frame");

    // R9 halt at frame boundary
    push(3'd1, 16'hC3A5, 16'h5AA5);
    push(3'd1, 16'h1357, 16'h2468);
    while (cs_n) tick();
    wr_cfg(4'd8, 16'h0003, 0);
    wait_frames(7);
    tick(40);
    chk(running === 0 && cs_n === 1 && frames_done == 7, "R9 halted after frame", {running, cs_n}, 2'b01);
    wr_cfg(4'd8, 16'h0001, 0);
    wait_frames(8);
    tick(2);
    drain("R9 R7 both words");

    // R10 freeze with and without freeze_en
    wr_cfg(4'd8, 16'h0005, 0);
    push(3'd0, 16'h0042, 16'h0018);
    push(3'd0, 16'h0024, 16'h0081);
    while (cs_n) tick();
    dbg_req = 1;
    wait_frames(9);
    tick(30);
    chk(running === 0 && cs_n === 1 && frames_done == 9, "R10 frozen at boundary", {running, cs_n}, 2'b01);
    dbg_req = 0;
    wait_frames(10);
    wr_cfg(4'd8, 16'h0001, 0);
    dbg_req = 1;
    push(3'd6, 16'h0ABC, 16'h0123);
    wait_frames(11);
    tick(3);
    chk(running === 1, "R10 debug ignored without freeze_en", running, 1);
    dbg_req = 0;
    drain("R10 R7 words");

    // R11 module disable mid-frame
    push(3'd1, 16'hF00D, 16'h7E81);
    while (cs_n) tick();
    tick(5);
    mdis = 1;
    tick(2);
    sck_h = sck; cs_h = cs_n; mosi_h = mosi; stable_ok = 1;
    for (int i = 0; i < 12; i++) begin
      tick();
      if (sck !== sck_h || cs_n !== cs_h || mosi !== mosi_h || running !== 1) stable_ok = 0;
    end
    chk(stable_ok, "R11 pins held while disabled", stable_ok, 1);
    mdis = 0;
    wait_frames(12);
    tick(2);
    drain("R11 R7 resumed word");

    // R2/R11: no start while master off or disabled
    wr_cfg(4'd8, 16'h0000, 0);
    tick(3);
    fd = frames_done;
    push(3'd0, 16'h0055, 16'h00AA);
    tick(30);
    chk(running === 0 && cs_n === 1, "R2 no start with master off", {running, cs_n}, 2'b01);
    mdis = 1;
    wr_cfg(4'd8, 16'h0001, 0);
    tick(20);
    chk(running === 0 && frames_done == fd, "R11 no start while disabled", running, 0);
    mdis = 0;
    wait_frames(fd + 1);
    tick(2);
    drain("R12 R7 last word");
    chk(exp_q.size() == 0, "R3 all frames seen", exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule